// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Interface

This block is the digital front end of a four-channel converter whose codes are programmed serially. A host sends an 11-bit command over three wires: a serial clock, a data line and a load strobe. Each command names one of four channels with a 2-bit address, carries a span-select bit and an 8-bit code, and is shifted in with the most significant bit first. A falling edge of the load strobe files the command in the addressed channel's input latch. Every channel also has an output latch, which holds what the analog side sees.

A fourth pin, the commit line (active low), decides when output latches change. If it is low when the load strobe falls, the addressed channel's output latch takes the new value in the same step. If it is held high, commands collect in the input latches only. A later high-to-low transition of the commit line copies all four input latches into their output latches in one system-clock cycle. All four pins are asynchronous. They are brought into the system clock domain through two-flop synchronizers, and that clock must run at least eight times faster than the serial clock. The outputs are four codes, four span flags and a one-cycle update pulse per channel, meant for an analog model or a bench.

Top module: `quad_dac_frontend`

## Requirements
- R1: A command is 11 bits, shifted in MSB first: address bit 1, address bit 0, span bit, then code bits 7 down to 0. A bit is captured on each falling edge of the serial clock while the load strobe is high.
- R2: Only the last 11 bits shifted before the load strobe falls form the command. A 16-clock transfer made of two 8-clock bursts is therefore accepted, and its first 5 bits are discarded.
- R3: Address 00 selects channel 0 (code_o[7:0]), 01 channel 1, 10 channel 2 and 11 channel 3 (code_o[31:24]). Channel i's span flag is range_o[i].
- R4: If the commit line is low when the load strobe falls, only the addressed channel's output latch takes the new code and span. The other channels keep their outputs.
- R5: If the commit line is high when the load strobe falls, no output changes. A later falling edge of the commit line copies all four input latches into the output latches in the same cycle.
- R6: The span bit is stored per channel together with its code (0 = 1x reference, 1 = 2x reference) and appears on range_o.
- R7: Synchronous reset clears every input latch, output latch, span flag, update pulse and the shift register to 0.
- R8: A pin edge first sampled at system rising edge k acts on the outputs at rising edge k+2.
- R9: upd_o[i] is high for exactly the cycle in which channel i's output latch is written, and channel i's code and span never change in a cycle without that pulse. At one time, either one pulse is high or all of them are.
- R10: Falling edges of the serial clock while the load strobe is low do not shift. A second load strobe afterwards therefore re-files the unchanged previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock pin, asynchronous |
| ser_dat_i | input | 1 | Serial data pin, asynchronous |
| ser_ld_i | input | 1 | Load strobe pin; its falling edge files the command |
| commit_n_i | input | 1 | Commit line; low = immediate, falling edge = copy all |
| code_o | output | 32 | Four output-latch codes, channel 0 in the low byte |
| range_o | output | 4 | Per-channel span flag |
| upd_o | output | 4 | One-cycle pulse per output-latch write |

## Verification
A behavioural model in the bench tracks the pins with the stated latency and is compared with every output on every clock. Directed cases cover the following, with the fault each one exposes:
- A 16-clock transfer: a design that keeps the first bits would file a wrong address.
- Held commands under a high commit line: a design that leaks them would change outputs early.
- One commit edge releasing four channels: staggered or missing pulses would show.
- Serial clocks with the load strobe low: a design that shifts there would corrupt the re-filed word.
- Reset in the middle of a run, and the exact three-cycle latency from pin to output.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned NUM_CH    = 4;
  localparam int unsigned CODE_BITS = 8;
  localparam int unsigned ADDR_BITS = $clog2(NUM_CH);
  localparam int unsigned CMD_BITS  = ADDR_BITS + 1 + CODE_BITS;

  // Pin lanes inside the synchronizer vector
  localparam int unsigned PIN_SCLK  = 0;
  localparam int unsigned PIN_SDAT  = 1;
  localparam int unsigned PIN_LOAD  = 2;
  localparam int unsigned PIN_CMT   = 3;
  localparam int unsigned NUM_PINS  = 4;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, lvl_q, old_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= 1'b0;
        lvl_q[g]  <= 1'b0;
        old_q[g]  <= 1'b0;
      end else begin
        meta_q[g] <= pin_i[g];
        lvl_q[g]  <= meta_q[g];
        old_q[g]  <= lvl_q[g];
      end
    end
    assign fall_o[g] = old_q[g] & ~lvl_q[g];
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)          word_q <= '0;
    else if (shift_i) word_q <= {word_q[W-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic                  direct_i,
  input  logic                  commit_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  rng_i,
  input  logic [CODE_W-1:0]     code_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        range_o,
  output logic [NCH-1:0]        upd_o
);
  localparam int unsigned ENT_W = CODE_W + 1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [ENT_W-1:0] in_q, out_q;
    logic             upd_q;
    logic             hit, direct_wr;

    assign hit       = load_i && (addr_i == ADDR_W'(g));
    assign direct_wr = hit && direct_i;

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q  <= '0;
        out_q <= '0;
        upd_q <= 1'b0;
      end else begin
        if (hit) in_q <= {rng_i, code_i};
        if (direct_wr)     out_q <= {rng_i, code_i};
        else if (commit_i) out_q <= in_q;
        upd_q <= direct_wr | commit_i;
      end
    end

    assign code_o[g*CODE_W +: CODE_W] = out_q[CODE_W-1:0];
    assign range_o[g]                 = out_q[CODE_W];
    assign upd_o[g]                   = upd_q;
  end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
  parameter int unsigned NCH    = qdac_pkg::NUM_CH,
  parameter int unsigned CODE_W = qdac_pkg::CODE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk_i,
  input  logic                  ser_dat_i,
  input  logic                  ser_ld_i,
  input  logic                  commit_n_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        range_o,
  output logic [NCH-1:0]        upd_o
);
  import qdac_pkg::*;

  localparam int unsigned ADDR_W = $clog2(NCH);
  localparam int unsigned WORD_W = ADDR_W + 1 + CODE_W;

  logic [NUM_PINS-1:0] pins, lvl, fall;
  logic [WORD_W-1:0]   word;
  logic                shift_en;

  assign pins[PIN_SCLK] = ser_clk_i;
  assign pins[PIN_SDAT] = ser_dat_i;
  assign pins[PIN_LOAD] = ser_ld_i;
  assign pins[PIN_CMT]  = commit_n_i;

  qdac_sync #(.N(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pins),
    .lvl_o  (lvl),
    .fall_o (fall)
  );

  assign shift_en = fall[PIN_SCLK] & lvl[PIN_LOAD];

  qdac_shift #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift_en),
    .bit_i   (lvl[PIN_SDAT]),
    .word_o  (word)
  );

  qdac_bank #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load_i   (fall[PIN_LOAD]),
    .direct_i (~lvl[PIN_CMT]),
    .commit_i (fall[PIN_CMT]),
    .addr_i   (word[WORD_W-1 -: ADDR_W]),
    .rng_i    (word[CODE_W]),
    .code_i   (word[CODE_W-1:0]),
    .code_o   (code_o),
    .range_o  (range_o),
    .upd_o    (upd_o)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH*CODE_W-1:0] code_o,
  input logic [NCH-1:0]        range_o,
  input logic [NCH-1:0]        upd_o
);
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (code_o == '0 && range_o == '0 && upd_o == '0));

  p_pulse_shape_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(upd_o) <= 1 || upd_o == '1));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !upd_o[g] |-> $stable(code_o[g*CODE_W +: CODE_W]));
    p_range_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !upd_o[g] |-> $stable(range_o[g]));
  end
endmodule

bind quad_dac_frontend qdac_checker #(.NCH(NCH), .CODE_W(CODE_W)) u_qdac_chk (
  .clk     (clk),
  .rst     (rst),
  .code_o  (code_o),
  .range_o (range_o),
  .upd_o   (upd_o)
);

// File: tb/quad_dac_frontend_bench.sv
`timescale 1ns/1ps
module quad_dac_frontend_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdat = 1'b0, sld = 1'b1, cmt = 1'b0;
  logic [31:0] code_o;
  logic [3:0]  range_o, upd_o;

  int tests = 0, fails = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  quad_dac_frontend u_quad_dac_frontend (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_ld_i(sld), .commit_n_i(cmt),
    .code_o(code_o), .range_o(range_o), .upd_o(upd_o)
  );

  // ---------------- reference model ----------------
  logic [3:0]  h0 = 0, h1 = 0, h2 = 0;  // pin history {cmt,ld,dat,clk}
  logic [10:0] m_word = 0;
  int          m_code[4];
  int          m_in[4];
  int          m_rng[4], m_inr[4];
  logic [3:0]  m_upd = 0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      h0 = 0; h1 = 0; h2 = 0; m_word = 0; m_upd = 0;
      for (int i = 0; i < 4; i++) begin
        m_code[i] = 0; m_in[i] = 0; m_rng[i] = 0; m_inr[i] = 0;
      end
    end else begin
      bit ck_f, ld_f, cm_f, direct;
      int a;
      ck_f   = h2[0] & ~h1[0];
      ld_f   = h2[2] & ~h1[2];
      cm_f   = h2[3] & ~h1[3];
      direct = ~h1[3];
      a      = m_word[10:9];
      m_upd  = 0;
      if (cm_f)
        for (int i = 0; i < 4; i++) begin
          m_code[i] = m_in[i]; m_rng[i] = m_inr[i]; m_upd[i] = 1;
        end
      if (ld_f) begin
        m_in[a] = m_word[7:0]; m_inr[a] = m_word[8];
        if (direct) begin
          m_code[a] = m_word[7:0]; m_rng[a] = m_word[8]; m_upd[a] = 1;
        end
      end
      if (ck_f && h1[2]) m_word = {m_word[9:0], h1[1]};
      h2 = h1; h1 = h0; h0 = {cmt, sld, sdat, sclk};
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 latency, R9 pulses)
  always @(negedge clk) if (started) begin
    for (int i = 0; i < 4; i++) begin
      chk("R8 model code", int'(code_o[i*8 +: 8]), m_code[i]);
      chk("R6 model range", int'(range_o[i]), m_rng[i]);
    end
    chk("R9 model upd", int'(upd_o), int'(m_upd));
  end

  // ---------------- stimulus helpers ----------------
  localparam int HALF = 6;

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(int n, logic [15:0] w);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i]; sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
  endtask

  task automatic load_pulse();
    sld = 1'b0; wait_clk(HALF); sld = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_cmd(int a, int r, int c);
    send_bits(11, 16'({a[1:0], r[0], c[7:0]}));
    load_pulse();
  endtask

  function automatic int ch(int i);
    return int'(code_o[i*8 +: 8]);
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R7 reset state
    chk("R7 codes after reset", int'(code_o), 0);
    chk("R7 ranges after reset", int'(range_o), 0);

    // R1 R3 R4: immediate update of channel 1 only
    send_cmd(1, 0, 8'hA5);
    chk("R4 ch1 immediate", ch(1), 8'hA5);
    chk("R4 ch0 untouched", ch(0), 0);
    chk("R4 ch2 untouched", ch(2), 0);

    // R3 R6: every address, span bits
    send_cmd(0, 1, 8'h3C);
    send_cmd(2, 0, 8'h81);
    send_cmd(3, 1, 8'hFF);
    chk("R3 ch0", ch(0), 8'h3C);
    chk("R3 ch2", ch(2), 8'h81);
    chk("R3 ch3", ch(3), 8'hFF);
    chk("R6 range flags", int'(range_o), 4'b1001);

    // R2: 16-clock transfer, first 5 bits are junk
    send_bits(16, {5'b11111, 2'd2, 1'b0, 8'h42});
    load_pulse();
    chk("R2 ch2 from 16-clock burst", ch(2), 8'h42);
    chk("R2 ch3 not hit", ch(3), 8'hFF);

    // R5: hold with commit line high, then commit all
    cmt = 1'b1; wait_clk(HALF);
    send_cmd(0, 0, 8'h11);
    send_cmd(1, 1, 8'h22);
    chk("R5 ch0 held", ch(0), 8'h3C);
    chk("R5 ch1 held", ch(1), 8'hA5);
    chk("R5 ranges held", int'(range_o), 4'b1001);
    cmt = 1'b0;
    wait_clk(2);
    chk("R8 no change before latency", int'(upd_o), 0);
    wait_clk(1);
    chk("R5 all pulses same cycle", int'(upd_o), 4'hF);
    wait_clk(1);
    chk("R9 pulse one cycle", int'(upd_o), 0);
    chk("R5 ch0 committed", ch(0), 8'h11);
    chk("R5 ch1 committed", ch(1), 8'h22);
    chk("R5 ch2 committed", ch(2), 8'h42);
    chk("R6 ranges committed", int'(range_o), 4'b1010);

    // R10: clocks while load low are ignored
    send_bits(11, {5'd0, 2'd3, 1'b0, 8'h5A});
    load_pulse();
    sld = 1'b0; wait_clk(HALF);
    send_bits(4, 16'hF);
    sld = 1'b1; wait_clk(HALF);
    chk("R10 ch3 first", ch(3), 8'h5A);
    load_pulse();
    chk("R10 ch3 after re-file", ch(3), 8'h5A);
    chk("R10 ch0 unchanged", ch(0), 8'h11);

    // R8: exact latency of a load strobe
    send_bits(11, {5'd0, 2'd0, 1'b1, 8'h77});
    sld = 1'b0;
    wait_clk(2);
    chk("R8 latency not yet", int'(upd_o), 0);
    wait_clk(1);
    chk("R8 latency pulse", int'(upd_o), 4'b0001);
    chk("R8 ch0 value", ch(0), 8'h77);
    wait_clk(HALF); sld = 1'b1; wait_clk(HALF);

    // R7: reset mid-run
    rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(1);
    chk("R7 codes after mid reset", int'(code_o), 0);
    chk("R7 ranges after mid reset", int'(range_o), 0);
    cmt = 1'b1; wait_clk(4); cmt = 1'b0; wait_clk(6);
    chk("R7 input latches cleared", int'(code_o), 0);

    wait_clk(10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule